// File: doc/BRIEF.md
# SPI Burst Master Controller

This block is an SPI master that runs one framed burst for each start command. Software sets a total byte count, a transmit count that says how many of the leading bytes are taken from the transmit FIFO, and a discard option. It then writes the start bit. The controller pulls chip select low, shifts the whole burst and raises chip select again. Once the transmit count is used up, the rest of the burst is clocked out as 0x00 filler bytes so that the slave's reply can be captured. Received bytes go into a receive FIFO. In discard mode, bytes captured while the transmit bytes were shifting are left out, so only the reply remains. For example, a 5-byte burst with 1 transmit byte leaves 4 bytes to read.

Bytes are loaded and unloaded through byte-wide push and pop ports. A small register port holds the counts, the divider, the start bit and two self-clearing FIFO reset bits. The serial clock is derived from the system clock by a programmable divider.

The control path is a five-state machine:
- ST_IDLE: chip select is high. A start write with a non-zero total moves it to ST_LOAD.
- ST_LOAD: fetches the next byte and decrements the byte counters, then always moves to ST_LOW.
- ST_LOW: the serial-clock low phase. At the divider tick it samples MISO and moves to ST_HIGH.
- ST_HIGH: the serial-clock high phase. At the tick it moves on as follows:
  - to ST_LOW if the byte is not finished;
  - to ST_LOAD if the byte is finished and bytes remain;
  - to ST_DONE after the last bit.
- ST_DONE: raises chip select and returns to ST_IDLE.

Top module: `spi_burst_ctrl`

## Requirements
- R1: Chip select stays low for the whole burst, with exactly `total` bytes shifted, and is high whenever the block is idle. The serial clock is low whenever chip select is high.
- R2: The first `min(txcnt,total)` bytes shifted are taken in order from the transmit FIFO. Every later byte of the burst is sent as 0x00.
- R3: If the transmit FIFO is empty when a transmit byte is due, 0x00 is sent in its place and the transmit count still advances.
- R4: With the discard bit (bit 0 of register 0) set, bytes captured during transmit bytes are not written to the receive FIFO. With it clear, every captured byte is written, in order.
- R5: Writing bit 31 of register 0 starts a burst. The bit reads 1 until the last byte has finished, then reads 0. A start while `total` (register 2) is 0 is ignored.
- R6: Writing 1 to bit 31 of register 1 empties the transmit FIFO, and writing 1 to bit 15 empties the receive FIFO. Each bit reads 1 in the cycle after the write and 0 after that.
- R7: SPI mode 0, MSB first. MOSI changes only while the serial clock is low, and the slave samples it on the rising edge. MISO is sampled by the controller at the rising edge.
- R8: With divider register 4 set to D, each serial-clock high phase lasts D+1 system clocks.
- R9: Each FIFO holds 64 bytes. A push into a full transmit FIFO is ignored. A pop from an empty receive FIFO is ignored, and `rx_data` reads 0x00 while that FIFO is empty.
- R10: After reset, chip select is high, the serial clock is low, register 0 reads 0 and `rx_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 FIFO reset, 2 total, 3 transmit count, 4 divider) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | 8 | Transmit byte |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO, 0 when empty |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The high-phase length property assumes the divider register is not rewritten while a burst is running. The bench only writes the divider and the counts while the controller is idle. The properties also assume MISO is stable at the cycle the controller samples it. The bench's slave model changes MISO only on falling serial-clock edges, which always occur at least one system clock before the next sample. Transmit pushes happen only before a start, so expected MOSI bytes follow directly from the push order and the counts.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } burst_state_e;

    localparam logic [2:0] ADDR_XFER  = 3'd0;
    localparam logic [2:0] ADDR_FIFO  = 3'd1;
    localparam logic [2:0] ADDR_TOTAL = 3'd2;
    localparam logic [2:0] ADDR_TXCNT = 3'd3;
    localparam logic [2:0] ADDR_DIV   = 3'd4;

    localparam int unsigned BIT_START   = 31;
    localparam int unsigned BIT_DISCARD = 0;
    localparam int unsigned BIT_TXRST   = 31;
    localparam int unsigned BIT_RXRST   = 15;

endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [WIDTH-1:0]         din,
    input  logic                     pop,
    output logic [WIDTH-1:0]         dout,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp;
    logic [AW:0]      rp;
    logic             do_push;
    logic             do_pop;

    assign level   = wp - rp;
    assign empty   = (level == '0);
    assign full    = (level == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp[AW-1:0]] <= din;
    end

endmodule

// File: rtl/spi_burst_clkdiv.sv
module spi_burst_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
    import spi_burst_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DIV_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_push,
    input  logic [7:0]  tx_data,
    input  logic        rx_pop,
    output logic [7:0]  rx_data,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH) + 1;

    burst_state_e     state_q, state_d;
    logic             discard_q;
    logic [CNT_W-1:0] total_q, txcnt_q;
    logic [DIV_W-1:0] div_q;
    logic             txrst_q, rxrst_q;
    logic [CNT_W-1:0] tx_left, tot_left;
    logic             in_tx;
    logic [7:0]       tx_sh, rx_sh;
    logic [2:0]       bit_cnt;
    logic             busy, run, tick, start_req;
    logic             tx_pop, rx_push;
    logic [7:0]       tx_head, rx_head;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic             unused_ok;

    assign unused_ok = ^{reg_wdata, tx_full, rx_full, tx_level, rx_level};

    // register port
    assign start_req = reg_wr && (reg_addr == ADDR_XFER) && reg_wdata[BIT_START]
                       && (state_q == ST_IDLE) && (total_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            discard_q <= 1'b0;
            total_q   <= '0;
            txcnt_q   <= '0;
            div_q     <= '0;
            txrst_q   <= 1'b0;
            rxrst_q   <= 1'b0;
        end else begin
            txrst_q <= 1'b0;
            rxrst_q <= 1'b0;
            if (reg_wr) begin
                unique case (reg_addr)
                    ADDR_XFER:  discard_q <= reg_wdata[BIT_DISCARD];
                    ADDR_FIFO: begin
                        txrst_q <= reg_wdata[BIT_TXRST] && !txrst_q;
                        rxrst_q <= reg_wdata[BIT_RXRST] && !rxrst_q;
                    end
                    ADDR_TOTAL: total_q <= reg_wdata[CNT_W-1:0];
                    ADDR_TXCNT: txcnt_q <= reg_wdata[CNT_W-1:0];
                    ADDR_DIV:   div_q   <= reg_wdata[DIV_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_XFER: begin
                reg_rdata[BIT_START]   = busy;
                reg_rdata[BIT_DISCARD] = discard_q;
            end
            ADDR_FIFO: begin
                reg_rdata[BIT_TXRST] = txrst_q;
                reg_rdata[BIT_RXRST] = rxrst_q;
            end
            ADDR_TOTAL: reg_rdata = 32'(total_q);
            ADDR_TXCNT: reg_rdata = 32'(txcnt_q);
            ADDR_DIV:   reg_rdata = 32'(div_q);
            default:    reg_rdata = '0;
        endcase
    end

    // FIFOs
    spi_burst_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(txrst_q),
        .push(tx_push), .din(tx_data), .pop(tx_pop),
        .dout(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    spi_burst_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rxrst_q),
        .push(rx_push), .din(rx_sh), .pop(rx_pop),
        .dout(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    assign rx_data = rx_empty ? 8'h00 : rx_head;

    spi_burst_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_LOW;
            ST_LOW:  if (tick) state_d = ST_HIGH;
            ST_HIGH: begin
                if (tick) begin
                    if (bit_cnt != 3'd7)       state_d = ST_LOW;
                    else if (tot_left == '0)   state_d = ST_DONE;
                    else                       state_d = ST_LOAD;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs_n = 1'b1;
        sclk = 1'b0;
        busy = 1'b1;
        run  = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_LOAD: cs_n = 1'b0;
            ST_LOW:  begin cs_n = 1'b0; run = 1'b1; end
            ST_HIGH: begin cs_n = 1'b0; run = 1'b1; sclk = 1'b1; end
            ST_DONE: cs_n = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign mosi    = cs_n ? 1'b0 : tx_sh[7];
    assign tx_pop  = (state_q == ST_LOAD) && (tx_left != '0) && !tx_empty;
    assign rx_push = (state_q == ST_HIGH) && tick && (bit_cnt == 3'd7)
                     && !(discard_q && in_tx);

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_left  <= '0;
            tot_left <= '0;
            in_tx    <= 1'b0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            bit_cnt  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        tx_left  <= txcnt_q;
                        tot_left <= total_q;
                    end
                end
                ST_LOAD: begin
                    in_tx    <= (tx_left != '0);
                    tx_sh    <= tx_pop ? tx_head : 8'h00;
                    bit_cnt  <= '0;
                    tot_left <= tot_left - 1'b1;
                    if (tx_left != '0) tx_left <= tx_left - 1'b1;
                end
                ST_LOW: begin
                    if (tick) rx_sh <= {rx_sh[6:0], miso};
                end
                ST_HIGH: begin
                    if (tick && bit_cnt != 3'd7) begin
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned LVL_W = 7,
    parameter int unsigned DEPTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk,
    input logic             cs_n,
    input logic             mosi,
    input logic             busy,
    input logic [DIV_W-1:0] div_q,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level
);
    logic [DIV_W:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hi_cnt <= '0;
        else if (sclk) hi_cnt <= hi_cnt + 1'b1;
        else           hi_cnt <= '0;
    end

    p_idle_clk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_idle_cs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    p_high_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_cnt == ({1'b0, div_q} + 1'b1)));

    p_tx_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(DEPTH));

    p_rx_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LVL_W'(DEPTH));

endmodule

bind spi_burst_ctrl spi_burst_chk #(
    .DIV_W(DIV_W),
    .LVL_W(LVL_W),
    .DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .sclk(sclk),
    .cs_n(cs_n),
    .mosi(mosi),
    .busy(busy),
    .div_q(div_q),
    .tx_level(tx_level),
    .rx_level(rx_level)
);

// File: tb/spi_burst_ctrl_test.sv
module spi_burst_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic        sclk, cs_n, mosi;
    logic        miso;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_mosi[$];
    logic [7:0] exp_rx[$];
    logic [7:0] seed = 8'h00;

    // slave model state
    int         s_bit = 0;
    int         s_byte = 0;
    logic [7:0] s_out = 8'h00;
    logic [7:0] s_cap = 8'h00;

    always #2 clk = ~clk;

    spi_burst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
        .tx_data(tx_data), .rx_pop(rx_pop), .rx_data(rx_data),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    assign miso = s_out[7];

    function automatic logic [7:0] resp(int k);
        return 8'(seed + 8'(k * 29));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slave: reply bytes and MOSI scoreboard monitor
    always @(negedge cs_n) begin
        s_bit = 0;
        s_byte = 0;
        s_out = resp(0);
    end

    always @(posedge sclk) begin
        s_cap = {s_cap[6:0], mosi};
        s_bit++;
        if (s_bit == 8) begin
            s_bit = 0;
            s_byte++;
            if (exp_mosi.size() == 0) begin
                check(1'b0, "R1 extra byte", s_cap, 0);
            end else begin
                logic [7:0] e;
                e = exp_mosi.pop_front();
                check(s_cap == e, "R2/R7 mosi byte", s_cap, e);
            end
        end
    end

    always @(negedge sclk) begin
        if (s_bit == 0) s_out = resp(s_byte);
        else            s_out = {s_out[6:0], 1'b0};
    end

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push_tx(logic [7:0] b);
        @(negedge clk);
        tx_push = 1'b1; tx_data = b;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        @(negedge clk);
        b = rx_data;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] d;
        d = 32'h8000_0000;
        while (d[31]) reg_read(3'd0, d);
    endtask

    // driver: loads stimulus, queues expected MOSI and RX bytes
    task automatic run_burst(int total, int txn, bit disc, int npush,
                             logic [7:0] base, logic [7:0] sd, bit drain, string req);
        logic [31:0] d;
        logic [7:0]  b;
        seed = sd;
        for (int i = 0; i < npush; i++) push_tx(8'(base + 8'(i)));
        for (int k = 0; k < total; k++) begin
            if (k < txn && k < npush && k < 64) exp_mosi.push_back(8'(base + 8'(k)));
            else                                exp_mosi.push_back(8'h00);
            if (!(disc && k < txn)) exp_rx.push_back(resp(k));
        end
        reg_write(3'd2, 32'(total));
        reg_write(3'd3, 32'(txn));
        reg_write(3'd0, 32'h8000_0000 | 32'(disc));
        #1 d = reg_rdata;
        check(d[31] == 1'b1, "R5 busy after start", d[31], 1);
        check(cs_n == 1'b0, "R1 cs low in burst", cs_n, 0);
        wait_done();
        check(cs_n == 1'b1, "R1 cs high after burst", cs_n, 1);
        check(exp_mosi.size() == 0, "R1 all bytes shifted", exp_mosi.size(), 0);
        if (drain) begin
            while (exp_rx.size() > 0) begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                pop_rx(b);
                check(b == e, req, b, e);
            end
            #1 check(rx_data == 8'h00, "R9 rx empty after drain", rx_data, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  b;
        int          hc;

        repeat (3) @(negedge clk);
        // R10 reset state
        #1;
        check(cs_n == 1'b1, "R10 cs_n reset", cs_n, 1);
        check(sclk == 1'b0, "R10 sclk reset", sclk, 0);
        check(rx_data == 8'h00, "R10 rx_data reset", rx_data, 0);
        rst_n = 1'b1;
        reg_read(3'd0, d);
        check(d == 32'h0, "R10 control reg reset", d, 0);

        reg_write(3'd4, 32'd1);
        // R4 discard: 5 total, 1 transmitted, 4 kept
        run_burst(5, 1, 1'b1, 1, 8'h9F, 8'h40, 1'b1, "R4 discard rx byte");
        // R4/R2 no discard: all captured bytes kept
        run_burst(3, 2, 1'b0, 2, 8'hA1, 8'h17, 1'b1, "R4 keep rx byte");
        // R3 underrun: 3 transmit bytes wanted, only 1 pushed
        run_burst(4, 3, 1'b0, 1, 8'h3C, 8'h88, 1'b1, "R3 underrun rx byte");

        // R5 start with total 0 ignored
        reg_write(3'd2, 32'd0);
        reg_write(3'd0, 32'h8000_0000);
        #1 check(reg_rdata[31] == 1'b0, "R5 zero total ignored", reg_rdata[31], 0);
        check(cs_n == 1'b1, "R5 cs stays high", cs_n, 1);

        // R8 divider: high phase D+1 clocks
        reg_write(3'd4, 32'd3);
        seed = 8'h05;
        push_tx(8'hC3);
        exp_mosi.push_back(8'hC3);
        reg_write(3'd2, 32'd1);
        reg_write(3'd3, 32'd1);
        reg_write(3'd0, 32'h8000_0001);
        while (sclk == 1'b0) @(negedge clk);
        hc = 0;
        while (sclk == 1'b1) begin hc++; @(negedge clk); end
        check(hc == 4, "R8 high phase length", hc, 4);
        wait_done();
        check(exp_mosi.size() == 0, "R8 byte shifted", exp_mosi.size(), 0);

        // R6 tx reset: pushed bytes flushed, burst sends 0x00
        reg_write(3'd4, 32'd1);
        push_tx(8'h11);
        push_tx(8'h22);
        reg_write(3'd1, 32'h8000_0000);
        #1 check(reg_rdata[31] == 1'b1, "R6 tx reset reads 1", reg_rdata[31], 1);
        reg_read(3'd1, d);
        check(d[31] == 1'b0, "R6 tx reset self-clears", d[31], 0);
        run_burst(1, 1, 1'b1, 0, 8'h00, 8'h61, 1'b1, "R6 rx byte");

        // R6 rx reset: two captured bytes dropped
        run_burst(2, 0, 1'b0, 0, 8'h00, 8'h72, 1'b0, "R6 rx keep");
        #1 check(rx_data == resp(0), "R6 rx filled before reset", rx_data, resp(0));
        exp_rx.delete();
        reg_write(3'd1, 32'h0000_8000);
        #1 check(reg_rdata[15] == 1'b1, "R6 rx reset reads 1", reg_rdata[15], 1);
        reg_read(3'd1, d);
        check(d[15] == 1'b0, "R6 rx reset self-clears", d[15], 0);
        check(rx_data == 8'h00, "R6 rx empty after reset", rx_data, 0);

        // R9 pop on empty ignored
        pop_rx(b);
        check(b == 8'h00, "R9 empty pop reads 0", b, 0);
        run_burst(1, 0, 1'b0, 0, 8'h00, 8'h2B, 1'b1, "R9 rx after empty pop");

        // R9 tx full: 65 pushes, only 64 kept, 65th byte sent as 0x00
        reg_write(3'd4, 32'd0);
        run_burst(65, 65, 1'b1, 65, 8'h01, 8'h90, 1'b1, "R9 rx none");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule